// File: doc/BRIEF.md
# Six-Pin Bidirectional General-Purpose I/O Port

This block is a six-pin general-purpose I/O port that sits on a simple byte-wide CPU register bus. Software controls it through three addresses. One holds an output data latch for the five lower pins. One holds a direction register for all six pins. The third is a read-only window onto the synchronized pin levels. A single-bit set/clear access changes one bit of the direction or data register and leaves every other bit as it was, so software can flip one pin without a read-modify-write sequence.

Pins 0 to 4 are push-pull outputs. When one of them is an input, it can be given a pull-up. The top pin has no data latch and only ever drives low (open-drain). It can also be handed over to the reset function, and then its direction bit no longer matters. A global pull-up-disable input overrides every pull-up. A sleep input disconnects the digital input path of the pins that are shared with analog inputs (pins 2 to 5), so that an analog voltage on those pins does not toggle the synchronizers.

Pad controls are registered, and so is the read data. Pad outputs follow a register change by one clock. A pin level appears at the pin-read address three clocks after it changes: two synchronizer flops, then the read register.

Top module: `gpio6_port`

## Requirements
- R1: After a synchronous reset, the direction and data registers are 0, and `pad_oe`, `pad_out` and `pad_pullup` are all 0.
- R2: A bus write to address 0x17 loads direction bits 5..0. A write to 0x18 loads data bits 4..0. Reading either address returns the stored bits, with every unimplemented bit reading 0. A write to 0x16 changes nothing.
- R3: `bus_rdata` is registered from `bus_addr` on every clock. Address 0x16 returns the two-flop-synchronized pin levels in bits 5..0, with bits 7..6 at 0. Any address other than 0x16, 0x17 and 0x18 reads 0.
- R4: When `bit_en` is high, `bus_wr` is low and `bus_addr` is 0x17 or 0x18, bit `bit_idx` of that register is set if `bit_val` is 1 and cleared if `bit_val` is 0. No other bit changes. An index beyond the register's implemented width has no effect, and `bus_wr` takes priority over `bit_en`.
- R5: For pins 0..4, `pad_oe[i]` equals direction bit i and `pad_out[i]` equals data bit i, one clock after the register changes.
- R6: For pins 0..4, `pad_pullup[i]` is 1 exactly when direction bit i is 0, data bit i is 1 and `pud_all` is 0. `pad_pullup[5]` is always 0.
- R7: While `pud_all` is high, every `pad_pullup` bit is 0 on the next clock, whatever the register contents.
- R8: Pin 5 is open-drain: `pad_out[5]` is always 0 and `pad_oe[5]` follows direction bit 5.
- R9: While `reset_pin_mode` is high, `pad_oe[5]` is 0 on the next clock, regardless of direction bit 5.
- R10: While `sleep_gate` is high, pins 2..5 are seen as 0 at the synchronizer input, so the pin-read address returns 0 in bits 5..2. Pins 0..1 are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 6 | Register address for reads, writes and bit operations |
| bus_wr | input | 1 | Byte write strobe |
| bus_wdata | input | 8 | Byte write data |
| bit_en | input | 1 | Single-bit set/clear strobe |
| bit_val | input | 1 | Bit operation value: 1 sets, 0 clears |
| bit_idx | input | 3 | Bit position for the bit operation |
| bus_rdata | output | 8 | Registered read data for the previous cycle's address |
| pin_in | input | 6 | Levels sensed at the pads |
| pud_all | input | 1 | Global pull-up disable |
| reset_pin_mode | input | 1 | Pin 5 is used as the reset input |
| sleep_gate | input | 1 | Low-power mode: disconnect the digital inputs of pins 2..5 |
| pad_oe | output | 6 | Per-pin output enable |
| pad_out | output | 6 | Per-pin output level |
| pad_pullup | output | 6 | Per-pin pull-up enable |

## Verification
The bench drives every combination of direction, data, pull-up disable and reset-pin mode, and compares each pad control with an arithmetic model. A design that enabled the pull-up on an output pin, enabled it while disable was asserted, or drove pin 5 while it served as reset shows up as a mismatch. Bit set and clear are swept over every index on both registers from several start patterns. A design that disturbed a neighbouring bit, wrote past the implemented width, or let a bit operation win over a byte write reads back the wrong value. All 64 pin patterns are read with sleep off and on. This catches an input gate on the wrong pins, and a design that reads the data latch instead of the pins.

// File: rtl/gpio6_pkg.sv
package gpio6_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 6;
  localparam logic [ADDR_W-1:0] ADR_PINS = 6'h16;
  localparam logic [ADDR_W-1:0] ADR_DIR  = 6'h17;
  localparam logic [ADDR_W-1:0] ADR_LAT  = 6'h18;
endpackage

// File: rtl/gpio6_regs.sv
module gpio6_regs
  import gpio6_pkg::*;
#(
  parameter int NPINS = 6,
  parameter int NLAT  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              bit_en,
  input  logic              bit_val,
  input  logic [2:0]        bit_idx,
  output logic [NPINS-1:0]  dir_q,
  output logic [NLAT-1:0]   lat_q
);

  logic [DATA_W-1:0] sel;
  logic              unused_hi;

  assign sel       = DATA_W'(1) << bit_idx;
  assign unused_hi = ^{wr_data[DATA_W-1:NLAT], sel[DATA_W-1:NLAT]};

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q <= '0;
      lat_q <= '0;
    end else if (wr_en) begin
      if (addr == ADR_DIR) dir_q <= wr_data[NPINS-1:0];
      if (addr == ADR_LAT) lat_q <= wr_data[NLAT-1:0];
    end else if (bit_en) begin
      if (addr == ADR_DIR)
        dir_q <= bit_val ? (dir_q | sel[NPINS-1:0]) : (dir_q & ~sel[NPINS-1:0]);
      if (addr == ADR_LAT)
        lat_q <= bit_val ? (lat_q | sel[NLAT-1:0]) : (lat_q & ~sel[NLAT-1:0]);
    end
  end

  AST_BITOP_ISOLATED: assert property (@(posedge clk) disable iff (rst)
    (bit_en && !wr_en && addr == ADR_DIR) |=>
      (((dir_q ^ $past(dir_q)) & ~($past(sel[NPINS-1:0]))) == '0)); // R4

endmodule

// File: rtl/gpio6_insync.sv
module gpio6_insync #(
  parameter int NPINS  = 6,
  parameter int ANA_LO = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sleep,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] sync_q
);

  logic [NPINS-1:0] in_en;
  logic [NPINS-1:0] meta_q;

  for (genvar i = 0; i < NPINS; i++) begin : g_gate
    if (i >= ANA_LO) begin : g_ana
      assign in_en[i] = ~sleep;
    end else begin : g_dig
      assign in_en[i] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= pin_in & in_en;
      sync_q <= meta_q;
    end
  end

  AST_SLEEP_GATES_INPUT: assert property (@(posedge clk) disable iff (rst)
    ($past(sleep, 2) && $past(sleep)) |-> ((sync_q >> ANA_LO) == '0)); // R10

endmodule

// File: rtl/gpio6_padctl.sv
module gpio6_padctl #(
  parameter int NPINS = 6,
  parameter int NLAT  = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] dir_q,
  input  logic [NLAT-1:0]  lat_q,
  input  logic             pud,
  input  logic             rst_pin_mode,
  output logic [NPINS-1:0] oe_q,
  output logic [NPINS-1:0] out_q,
  output logic [NPINS-1:0] pu_q
);

  logic [NPINS-1:0] oe_d, out_d, pu_d;

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    if (i < NLAT) begin : g_pushpull
      assign oe_d[i]  = dir_q[i];
      assign out_d[i] = lat_q[i];
      assign pu_d[i]  = ~dir_q[i] & lat_q[i] & ~pud;
    end else if (i == NPINS-1) begin : g_od_rst
      assign oe_d[i]  = dir_q[i] & ~rst_pin_mode;
      assign out_d[i] = 1'b0;
      assign pu_d[i]  = 1'b0;
    end else begin : g_od
      assign oe_d[i]  = dir_q[i];
      assign out_d[i] = 1'b0;
      assign pu_d[i]  = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      oe_q  <= '0;
      out_q <= '0;
      pu_q  <= '0;
    end else begin
      oe_q  <= oe_d;
      out_q <= out_d;
      pu_q  <= pu_d;
    end
  end

endmodule

// File: rtl/gpio6_port.sv
module gpio6_port
  import gpio6_pkg::*;
#(
  parameter int NPINS  = 6,
  parameter int NLAT   = 5,
  parameter int ANA_LO = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bit_en,
  input  logic              bit_val,
  input  logic [2:0]        bit_idx,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NPINS-1:0]  pin_in,
  input  logic              pud_all,
  input  logic              reset_pin_mode,
  input  logic              sleep_gate,
  output logic [NPINS-1:0]  pad_oe,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_pullup
);

  logic [NPINS-1:0] dir_q;
  logic [NLAT-1:0]  lat_q;
  logic [NPINS-1:0] sync_q;
  logic [DATA_W-1:0] rd_d;

  gpio6_regs #(.NPINS(NPINS), .NLAT(NLAT)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .addr    (bus_addr),
    .wr_en   (bus_wr),
    .wr_data (bus_wdata),
    .bit_en  (bit_en),
    .bit_val (bit_val),
    .bit_idx (bit_idx),
    .dir_q   (dir_q),
    .lat_q   (lat_q)
  );

  gpio6_insync #(.NPINS(NPINS), .ANA_LO(ANA_LO)) u_insync (
    .clk    (clk),
    .rst    (rst),
    .sleep  (sleep_gate),
    .pin_in (pin_in),
    .sync_q (sync_q)
  );

  gpio6_padctl #(.NPINS(NPINS), .NLAT(NLAT)) u_padctl (
    .clk          (clk),
    .rst          (rst),
    .dir_q        (dir_q),
    .lat_q        (lat_q),
    .pud          (pud_all),
    .rst_pin_mode (reset_pin_mode),
    .oe_q         (pad_oe),
    .out_q        (pad_out),
    .pu_q         (pad_pullup)
  );

  always_comb begin
    unique case (bus_addr)
      ADR_PINS: rd_d = DATA_W'(sync_q);
      ADR_DIR:  rd_d = DATA_W'(dir_q);
      ADR_LAT:  rd_d = DATA_W'(lat_q);
      default:  rd_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_d;
  end

  AST_UNIMPL_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    ($past(bus_addr) == ADR_LAT) |-> (bus_rdata[DATA_W-1:NLAT] == '0)); // R2

  AST_PUD_FORCES_OFF: assert property (@(posedge clk) disable iff (rst)
    pud_all |=> (pad_pullup == '0)); // R7

  AST_RSTPIN_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
    reset_pin_mode |=> !pad_oe[NPINS-1]); // R9

endmodule

// File: tb/tb_gpio6_port.sv
`timescale 1ns/1ps
module tb_gpio6_port;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic       bit_en = 1'b0;
  logic       bit_val = 1'b0;
  logic [2:0] bit_idx = '0;
  logic [7:0] bus_rdata;
  logic [5:0] pin_in = '0;
  logic       pud_all = 1'b0;
  logic       reset_pin_mode = 1'b0;
  logic       sleep_gate = 1'b0;
  logic [5:0] pad_oe, pad_out, pad_pullup;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  localparam logic [5:0] A_PIN = 6'h16, A_DIR = 6'h17, A_LAT = 6'h18;

  always #4 clk = ~clk;

  gpio6_port dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic bitop(input logic [5:0] a, input logic [2:0] idx, input logic v);
    @(negedge clk); bus_addr = a; bit_idx = idx; bit_val = v; bit_en = 1'b1;
    @(negedge clk); bit_en = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a;
    @(negedge clk); d = bus_rdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 pad_oe", pad_oe, 0);
    chk("R1 pad_out", pad_out, 0);
    chk("R1 pad_pullup", pad_pullup, 0);
    rd(A_DIR, r); chk("R1 dir", r, 0);
    rd(A_LAT, r); chk("R1 lat", r, 0);

    wr(A_DIR, 8'hFF); rd(A_DIR, r); chk("R2 dir width", r, 8'h3F);
    wr(A_LAT, 8'hFF); rd(A_LAT, r); chk("R2 lat width", r, 8'h1F);
    wr(A_DIR, 8'h15); wr(A_LAT, 8'h0A);
    wr(A_PIN, 8'hFF);
    rd(A_DIR, r); chk("R2 pin-addr write ignored dir", r, 8'h15);
    rd(A_LAT, r); chk("R2 pin-addr write ignored lat", r, 8'h0A);
    rd(6'h10, r); chk("R3 unmapped read", r, 0);

    // priority: byte write beats bit op
    @(negedge clk); bus_addr = A_DIR; bus_wdata = 8'h00; bus_wr = 1'b1;
    bit_en = 1'b1; bit_idx = 3'd3; bit_val = 1'b1;
    @(negedge clk); bus_wr = 1'b0; bit_en = 1'b0;
    rd(A_DIR, r); chk("R4 write priority", r, 0);

    // bit set/clear sweep
    for (int reg_i = 0; reg_i < 2; reg_i++) begin
      logic [5:0] a;
      logic [7:0] m;
      a = (reg_i == 0) ? A_DIR : A_LAT;
      m = (reg_i == 0) ? 8'h3F : 8'h1F;
      for (int s = 0; s < 4; s++) begin
        logic [7:0] st;
        st = (s == 0) ? 8'h00 : (s == 1) ? 8'hFF : (s == 2) ? 8'h2A : 8'h15;
        for (int idx = 0; idx < 8; idx++) begin
          for (int v = 0; v < 2; v++) begin
            logic [7:0] e;
            wr(a, st);
            bitop(a, 3'(idx), v[0]);
            rd(a, r);
            e = (v == 1) ? ((st & m) | (8'd1 << idx)) : ((st & m) & ~(8'd1 << idx));
            e = e & m;
            chk("R4 bit op", r, e);
          end
        end
      end
    end

    // pad control sweep
    for (int rm = 0; rm < 2; rm++) begin
      for (int pd = 0; pd < 2; pd++) begin
        for (int d = 0; d < 64; d++) begin
          wr(A_DIR, 8'(d));
          for (int l = 0; l < 32; l++) begin
            logic [5:0] eoe, eout, epu;
            reset_pin_mode = rm[0];
            pud_all = pd[0];
            wr(A_LAT, 8'(l));
            @(negedge clk);
            eoe  = 6'(d) & ~((rm == 1) ? 6'h20 : 6'h00);
            eout = 6'(l) & 6'h1F;
            epu  = (pd == 1) ? 6'h00 : ((~6'(d)) & 6'(l) & 6'h1F);
            chk((rm == 1) ? "R9 R5 pad_oe" : "R5 R8 pad_oe", pad_oe, eoe);
            chk("R5 R8 pad_out", pad_out, eout);
            chk((pd == 1) ? "R7 pad_pullup" : "R6 pad_pullup", pad_pullup, epu);
          end
        end
      end
    end
    reset_pin_mode = 1'b0;
    pud_all = 1'b0;

    // pin read sweep with and without sleep gating
    for (int sl = 0; sl < 2; sl++) begin
      for (int p = 0; p < 64; p++) begin
        @(negedge clk); pin_in = 6'(p); sleep_gate = sl[0];
        repeat (3) @(negedge clk);
        rd(A_PIN, r);
        chk((sl == 1) ? "R10 pin read sleep" : "R3 pin read", r,
            (sl == 1) ? (8'(p) & 8'h03) : 8'(p));
      end
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule